// File: doc/BRIEF.md
# Fixed-Point Q15.16 by Q7.8 Divider

This block divides a signed 32-bit fixed-point value with 16 fraction bits by a signed 16-bit fixed-point value with 8 fraction bits. The divisor is sign-extended to 32 bits and moved up by eight places, so both operands carry the same scale of 2^16. The scales then cancel, and a plain integer division of the two raw words yields a quotient that is a whole number in ordinary 32-bit two's complement form.

The division runs over several clock cycles. Signs are removed first. An unsigned core then performs 32 iterations. Each iteration shifts the partial remainder left, brings in one dividend bit, and adds or subtracts the divisor according to the sign of the partial remainder. A final cycle corrects a negative remainder. The signs are put back on the way out, so the quotient is truncated toward zero and the remainder follows the sign of the dividend.

A caller pulses a start input with the operands. It waits for a single-cycle done pulse and then reads the quotient, the remainder and a divide-by-zero flag. All three hold until the next accepted start.

Top module: `fxdiv_q16q8`

## Requirements
- R1: While reset is applied and after its release, done, busy and the zero-divisor flag are low and quotient and remainder are zero.
- R2: A start sampled high at rising edge k while busy is low, with a nonzero divisor, raises busy from edge k. Busy falls and done is high for exactly the one cycle following edge k+33.
- R3: The quotient equals the signed dividend word divided by (signed divisor word × 256), truncated toward zero, as a 32-bit two's complement integer.
- R4: The remainder equals dividend − quotient × divisor × 256 in the dividend's 2^-16 units. It is zero or has the sign of the dividend, and its magnitude is below |divisor| × 256.
- R5: A start accepted with a divisor of zero keeps busy low. It raises the zero-divisor flag and done for the cycle after the start edge, and forces quotient and remainder to zero.
- R6: The zero-divisor flag stays high until the next accepted start with a nonzero divisor, which clears it from that start edge.
- R7: A start raised while busy is high is ignored. The running result, its done timing and the zero-divisor flag are unaffected.
- R8: While busy is low and no start arrives, quotient, remainder and the zero-divisor flag keep their values.
- R9: Extreme operands such as a dividend of −2^31, or a divisor of −32768 or 32767, give exact results with no loss of significant bits in the alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a division; ignored while busy |
| dividend_i | input | 32 | Signed dividend, 16 fraction bits |
| divisor_i | input | 16 | Signed divisor, 8 fraction bits |
| quotient_o | output | 32 | Signed integer quotient |
| remainder_o | output | 32 | Signed remainder, 16 fraction bits |
| done_o | output | 1 | One-cycle result-valid pulse |
| busy_o | output | 1 | Division in progress |
| div_zero_o | output | 1 | Last accepted divisor was zero |

## Verification
The assertions rely on start being honoured only when busy is low. They also rely on the core never being launched with a zero aligned divisor, which is what makes the partial-remainder bound and the final remainder range meaningful. The stimulus mixes full-range random words with small divisors, so that both large and small quotients occur. It also holds directed cases at the most negative dividend and the extreme divisors. Zero divisors and starts raised mid-operation are applied only in directed tests, so the random traffic always waits for done before the next start.

// File: rtl/fxdiv_pkg.sv
package fxdiv_pkg;
  // iteration controller states of the unsigned core
  typedef enum logic [1:0] {
    CORE_IDLE = 2'd0,
    CORE_RUN  = 2'd1,
    CORE_FIX  = 2'd2
  } core_state_t;
endpackage

// File: rtl/fxdiv_align.sv
// Brings the divisor onto the dividend's scale and strips operand signs.
module fxdiv_align #(
  parameter int NUM_W    = 32,
  parameter int DEN_W    = 16,
  parameter int NUM_FRAC = 16,
  parameter int DEN_FRAC = 8
) (
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic [NUM_W-1:0] num_mag_o,
  output logic [NUM_W-1:0] den_mag_o,
  output logic             q_neg_o,
  output logic             r_neg_o,
  output logic             den_zero_o
);
  localparam int SHIFT = NUM_FRAC - DEN_FRAC;
  localparam int EXT   = NUM_W - DEN_W;

  logic [NUM_W-1:0] den_ext;
  logic [NUM_W-1:0] den_aligned;
  logic             num_sign;
  logic             den_sign;

  assign num_sign    = num_i[NUM_W-1];
  assign den_sign    = den_i[DEN_W-1];
  // widen with sign copies first, then scale, so no top bits are dropped
  assign den_ext     = {{EXT{den_sign}}, den_i};
  assign den_aligned = den_ext << SHIFT;

  always_comb begin
    if (num_sign) num_mag_o = ~num_i + NUM_W'(1);
    else          num_mag_o = num_i;
    if (den_sign) den_mag_o = ~den_aligned + NUM_W'(1);
    else          den_mag_o = den_aligned;
  end

  assign q_neg_o    = num_sign ^ den_sign;
  assign r_neg_o    = num_sign;
  assign den_zero_o = (den_i == '0);
endmodule

// File: rtl/fxdiv_nr_core.sv
// Unsigned iterative non-restoring divider with one remainder fix-up cycle.
module fxdiv_nr_core
  import fxdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  localparam int AW = W + 2;
  localparam int CW = $clog2(W + 1);

  core_state_t   state_q, state_d;
  logic [AW-1:0] acc_q, acc_d;
  logic [W-1:0]  quo_q, quo_d;
  logic [W-1:0]  den_q, den_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          dp_en;

  logic [AW-1:0] den_wide;
  logic [AW-1:0] shifted;
  logic [AW-1:0] acc_step;
  logic [W-1:0]  quo_step;
  logic [AW-1:0] acc_fix;

  assign den_wide = {2'b00, den_q};
  assign shifted  = {acc_q[AW-2:0], quo_q[W-1]};
  assign acc_step = acc_q[AW-1] ? (shifted + den_wide) : (shifted - den_wide);
  assign quo_step = {quo_q[W-2:0], ~acc_step[AW-1]};
  assign acc_fix  = acc_q[AW-1] ? (acc_q + den_wide) : acc_q;

  assign dp_en = (state_q != CORE_IDLE) || start_i;

  always_comb begin
    state_d = state_q;
    acc_d   = acc_q;
    quo_d   = quo_q;
    den_d   = den_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    unique case (state_q)
      CORE_IDLE: begin
        if (start_i) begin
          acc_d   = '0;
          quo_d   = num_i;
          den_d   = den_i;
          cnt_d   = '0;
          state_d = CORE_RUN;
        end
      end
      CORE_RUN: begin
        acc_d = acc_step;
        quo_d = quo_step;
        cnt_d = cnt_q + CW'(1);
        if (cnt_q == CW'(W - 1)) state_d = CORE_FIX;
      end
      CORE_FIX: begin
        acc_d   = acc_fix;
        done_d  = 1'b1;
        state_d = CORE_IDLE;
      end
      default: state_d = CORE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CORE_IDLE;
      acc_q   <= '0;
      quo_q   <= '0;
      den_q   <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (dp_en) begin
        acc_q <= acc_d;
        quo_q <= quo_d;
        den_q <= den_d;
        cnt_q <= cnt_d;
      end
    end
  end

  assign busy_o = (state_q != CORE_IDLE);
  assign done_o = done_q;
  assign quo_o  = quo_q;
  assign rem_o  = acc_q[W-1:0];

  logic signed [AW-1:0] acc_s;
  logic signed [AW-1:0] den_s;
  assign acc_s = acc_q;
  assign den_s = den_wide;

  AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CORE_RUN) |-> (acc_s >= -den_s) && (acc_s < den_s)); // R4
  AST_REM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!acc_q[AW-1]) && (acc_s < den_s)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (state_q == CORE_IDLE)); // R2
endmodule

// File: rtl/fxdiv_sign.sv
// Restores signs on the unsigned core results and applies the zero-divisor force.
module fxdiv_sign #(
  parameter int W = 32
) (
  input  logic [W-1:0] quo_mag_i,
  input  logic [W-1:0] rem_mag_i,
  input  logic         q_neg_i,
  input  logic         r_neg_i,
  input  logic         force_zero_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  logic [W-1:0] quo_s;
  logic [W-1:0] rem_s;

  assign quo_s = q_neg_i ? (~quo_mag_i + W'(1)) : quo_mag_i;
  assign rem_s = r_neg_i ? (~rem_mag_i + W'(1)) : rem_mag_i;

  always_comb begin
    if (force_zero_i) begin
      quo_o = '0;
      rem_o = '0;
    end else begin
      quo_o = quo_s;
      rem_o = rem_s;
    end
  end
endmodule

// File: rtl/fxdiv_q16q8.sv
// Fixed-point divider: Q15.16 dividend over Q7.8 divisor, integer quotient.
module fxdiv_q16q8 #(
  parameter int NUM_W    = 32,
  parameter int DEN_W    = 16,
  parameter int NUM_FRAC = 16,
  parameter int DEN_FRAC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [NUM_W-1:0] dividend_i,
  input  logic [DEN_W-1:0] divisor_i,
  output logic [NUM_W-1:0] quotient_o,
  output logic [NUM_W-1:0] remainder_o,
  output logic             done_o,
  output logic             busy_o,
  output logic             div_zero_o
);
  localparam int LW = $clog2(NUM_W + 3) + 1;

  logic [NUM_W-1:0] num_mag;
  logic [NUM_W-1:0] den_mag;
  logic             q_neg;
  logic             r_neg;
  logic             den_zero;

  logic             core_busy;
  logic             core_done;
  logic [NUM_W-1:0] core_quo;
  logic [NUM_W-1:0] core_rem;

  logic accept;
  logic launch;
  logic zero_hit;

  logic err_q,   err_d;
  logic qneg_q,  qneg_d;
  logic rneg_q,  rneg_d;
  logic zdone_q, zdone_d;

  fxdiv_align #(
    .NUM_W(NUM_W), .DEN_W(DEN_W), .NUM_FRAC(NUM_FRAC), .DEN_FRAC(DEN_FRAC)
  ) u_align (
    .num_i      (dividend_i),
    .den_i      (divisor_i),
    .num_mag_o  (num_mag),
    .den_mag_o  (den_mag),
    .q_neg_o    (q_neg),
    .r_neg_o    (r_neg),
    .den_zero_o (den_zero)
  );

  assign accept   = start_i && !core_busy;
  assign launch   = accept && !den_zero;
  assign zero_hit = accept && den_zero;

  fxdiv_nr_core #(.W(NUM_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (launch),
    .num_i   (num_mag),
    .den_i   (den_mag),
    .busy_o  (core_busy),
    .done_o  (core_done),
    .quo_o   (core_quo),
    .rem_o   (core_rem)
  );

  always_comb begin
    err_d   = err_q;
    qneg_d  = qneg_q;
    rneg_d  = rneg_q;
    zdone_d = zero_hit;
    if (accept) begin
      err_d = den_zero;
      if (!den_zero) begin
        qneg_d = q_neg;
        rneg_d = r_neg;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= 1'b0;
      qneg_q  <= 1'b0;
      rneg_q  <= 1'b0;
      zdone_q <= 1'b0;
    end else begin
      zdone_q <= zdone_d;
      if (accept) begin
        err_q  <= err_d;
        qneg_q <= qneg_d;
        rneg_q <= rneg_d;
      end
    end
  end

  fxdiv_sign #(.W(NUM_W)) u_sign (
    .quo_mag_i    (core_quo),
    .rem_mag_i    (core_rem),
    .q_neg_i      (qneg_q),
    .r_neg_i      (rneg_q),
    .force_zero_i (err_q),
    .quo_o        (quotient_o),
    .rem_o        (remainder_o)
  );

  assign done_o     = core_done || zdone_q;
  assign busy_o     = core_busy;
  assign div_zero_o = err_q;

  // cycle counter used only by the latency check below
  logic [LW-1:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         lat_q <= '0;
    else if (launch)    lat_q <= '0;
    else if (core_busy) lat_q <= lat_q + LW'(1);
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    core_done |-> (lat_q == LW'(NUM_W + 1))); // R2
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && (divisor_i == '0)) |=> (done_o && div_zero_o && !busy_o)); // R5
  AST_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero_o |-> ((quotient_o == '0) && (remainder_o == '0))); // R5
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(quotient_o) && $stable(remainder_o) && $stable(div_zero_o))); // R8
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> !div_zero_o); // R7
endmodule

// File: tb/fxdiv_q16q8_tb.sv
module fxdiv_q16q8_tb;
  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [31:0] dividend_i;
  logic [15:0] divisor_i;
  logic [31:0] quotient_o;
  logic [31:0] remainder_o;
  logic        done_o;
  logic        busy_o;
  logic        div_zero_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  fxdiv_q16q8 u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .quotient_o(quotient_o), .remainder_o(remainder_o),
    .done_o(done_o), .busy_o(busy_o), .div_zero_o(div_zero_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_quo(input logic [31:0] a, input logic [15:0] d);
    longint av = longint'($signed(a));
    longint dv = longint'($signed(d)) * 256;
    return 32'(av / dv);
  endfunction

  function automatic logic [31:0] exp_rem(input logic [31:0] a, input logic [15:0] d);
    longint av = longint'($signed(a));
    longint dv = longint'($signed(d)) * 256;
    return 32'(av % dv);
  endfunction

  // one division; optional start pulse injected while busy (R7)
  task automatic run_op(input logic [31:0] a, input logic [15:0] d, input bit inject);
    int n;
    logic [31:0] eq, er;
    logic [31:0] hq, hr;
    @(negedge clk);
    start_i = 1'b1; dividend_i = a; divisor_i = d;
    @(negedge clk);
    start_i = 1'b0;
    n = 1;
    if (d != 16'h0) begin
      chk(busy_o === 1'b1, "R2 busy after start", {31'b0, busy_o}, 32'd1);
      chk(div_zero_o === 1'b0, "R6 flag cleared by start", {31'b0, div_zero_o}, 32'd0);
    end else begin
      chk(busy_o === 1'b0, "R5 busy stays low", {31'b0, busy_o}, 32'd0);
    end
    while (!done_o && n < 100) begin
      if (inject && n == 4) begin
        start_i = 1'b1; dividend_i = ~a; divisor_i = 16'h0000;
      end
      @(negedge clk);
      n++;
      if (inject && n == 5) start_i = 1'b0;
    end
    if (d == 16'h0) begin
      chk(n == 1, "R5 done latency", 32'(n), 32'd1);
      chk(div_zero_o === 1'b1, "R5 zero flag", {31'b0, div_zero_o}, 32'd1);
      chk(quotient_o === 32'h0, "R5 quotient zero", quotient_o, 32'h0);
      chk(remainder_o === 32'h0, "R5 remainder zero", remainder_o, 32'h0);
    end else begin
      eq = exp_quo(a, d);
      er = exp_rem(a, d);
      chk(n == 34, inject ? "R7 latency with ignored start" : "R2 done latency", 32'(n), 32'd34);
      chk(busy_o === 1'b0, "R2 busy low at done", {31'b0, busy_o}, 32'd0);
      chk(quotient_o === eq, inject ? "R7 quotient" : "R3 quotient", quotient_o, eq);
      chk(remainder_o === er, inject ? "R7 remainder" : "R4 remainder", remainder_o, er);
      chk(div_zero_o === 1'b0, "R7 zero flag low", {31'b0, div_zero_o}, 32'd0);
    end
    @(negedge clk);
    chk(done_o === 1'b0, "R2 done single cycle", {31'b0, done_o}, 32'd0);
    hq = quotient_o; hr = remainder_o;
    repeat (3) @(negedge clk);
    chk(quotient_o === hq && remainder_o === hr, "R8 outputs hold", quotient_o, hq);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] a;
    logic [15:0] d;
    int mode;
    start_i = 1'b0; dividend_i = '0; divisor_i = '0;
    rst_n = 1'b0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(done_o === 1'b0 && busy_o === 1'b0 && div_zero_o === 1'b0, "R1 flags in reset",
        {29'b0, done_o, busy_o, div_zero_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(quotient_o === 32'h0, "R1 quotient after reset", quotient_o, 32'h0);
    chk(remainder_o === 32'h0, "R1 remainder after reset", remainder_o, 32'h0);

    // directed: 3.0 / 1.5, -7.5 / 2.0, fractional remainder
    run_op(32'h0003_0000, 16'h0180, 0); // R3
    run_op(32'hFFF8_8000, 16'h0200, 0); // R3 R4
    run_op(32'h0001_2345, 16'hFF40, 0); // R4
    // extremes R9
    run_op(32'h8000_0000, 16'h0001, 0); // R9
    run_op(32'h8000_0000, 16'h8000, 0); // R9
    run_op(32'h7FFF_FFFF, 16'h7FFF, 0); // R9
    run_op(32'h7FFF_FFFF, 16'hFFFF, 0); // R9
    run_op(32'h0000_0000, 16'h1234, 0); // R3
    // zero divisor then recovery R5 R6
    run_op(32'h1234_5678, 16'h0000, 0); // R5
    run_op(32'h0010_0000, 16'h0100, 0); // R6
    // start while busy R7
    run_op(32'hDEAD_BEEF, 16'h0123, 1); // R7

    for (int i = 0; i < 300; i++) begin
      mode = int'($urandom % 4);
      a = $urandom;
      if ($urandom % 3 == 0) a = 32'($signed(a) >>> ($urandom % 24));
      case (mode)
        0: d = 16'($urandom % 15 + 1);
        1: d = 16'($urandom % 255 + 1);
        default: d = 16'($urandom);
      endcase
      if ($urandom % 2 == 1) d = -d;
      if (d == 16'h0) d = 16'h0001;
      run_op(a, d, 0); // R3 R4
    end

    ended = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule